// File: doc/BRIEF.md
# Shared-Bus Flash and Pseudo-SRAM Access Controller

This controller sits on the host side of one shared 16-bit address/data bus that reaches two memories: a flash device and a pseudo-SRAM. The host issues one request at a time through a valid/ready handshake. Each request carries a target select, a read or write flag, a word address, write data and per-byte enables. The controller then drives the active-low strobes of the chosen device. Every access length is a whole number of clock cycles, found by rounding each nanosecond timing parameter up against the clock period.

Exclusive bus ownership is the central rule. Only one device's chip enable may be low at any time. Whenever ownership passes from one device to the other, at least one full cycle with every enable released is inserted. The pseudo-SRAM's chip enable and output enable stay low after a read, which keeps the page open. A following read that stays inside the same eight-word page then completes with the short in-page latency. Any other request closes the page, and the next pseudo-SRAM read pays the full first-access latency again.

The top address bit goes to the flash only. The pseudo-SRAM can be put into deep power-down by a host level input while it is not in use.

Top module: `dualMemBusCtrl`

## Requirements
- R1: After reset every active-low strobe (both chip enables, output enables, write enables, flash address latch, both byte enables) is high, the power-down pin is high, the data bus is not driven, no response is pending and a request is accepted immediately.
- R2: The flash and pseudo-SRAM chip enables are never low in the same cycle. A cycle in which one of them is low is never directly followed by a cycle in which the other is low.
- R3: A flash read holds flash chip enable and output enable low for ceil(FLASH_RD_PS/CLK_PS) cycles (18 by default) and returns the full 16-bit word that many cycles after acceptance. The flash address latch is low only in the first cycle of each flash access.
- R4: A flash write holds flash chip enable and write enable low for ceil(WR_PULSE_PS/CLK_PS) cycles (12 by default) while driving the write data. Both rise at the same edge, so the word is captured at that edge. Flash output enable and write enable are never low together.
- R5: A pseudo-SRAM read that does not follow an open page returns its data ceil(PS_FIRST_PS/CLK_PS) cycles (18 by default) after acceptance.
- R6: A pseudo-SRAM read that arrives while the page is open, and whose address bits above bit 2 match the open page, is accepted without chip enable rising and returns after ceil(PS_PAGE_PS/CLK_PS) cycles (5 by default). While chip enable stays low, address bits above bit 2 do not change.
- R7: Any other request while the page is open releases pseudo-SRAM chip enable for at least one cycle before it is accepted. A pseudo-SRAM read to a different page then takes the full first-access latency.
- R8: Pseudo-SRAM byte enables follow the request: upper enable low for byte-enable bit 1 (data bits 15:8), lower enable low for bit 0 (bits 7:0). Both are high whenever pseudo-SRAM chip enable is high. A write changes only the enabled bytes, and a read returns zero in disabled lanes.
- R9: The top address output is driven from address bit 21 only while flash chip enable is low, and it is low during every pseudo-SRAM access.
- R10: While the sleep input is high and no pseudo-SRAM access is in progress, the power-down pin is low and pseudo-SRAM requests are held off. Flash requests are still served. Power-down is never low while pseudo-SRAM chip enable is low.
- R11: Ready is low while an access is in progress. Every read yields exactly one response cycle, and writes yield none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Host request valid |
| reqReady | output | 1 | Controller accepts the request this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqTarget | input | 1 | 0 = flash, 1 = pseudo-SRAM |
| reqAddr | input | 22 | Word address; bit 21 used by the flash only |
| reqWdata | input | 16 | Write data |
| reqByteEn | input | 2 | Active-high byte enables (bit 1 upper, bit 0 lower) |
| psramSleep | input | 1 | Request deep power-down of the pseudo-SRAM |
| rspValid | output | 1 | Read data valid, one cycle per read |
| rspData | output | 16 | Read data |
| memAddr | output | 21 | Shared address lines |
| flashAddrTop | output | 1 | Flash-only top address line |
| memDqOut | output | 16 | Data driven onto the bus |
| memDqOe | output | 1 | Bus drive enable |
| memDqIn | input | 16 | Data read from the bus |
| flashCeN | output | 1 | Flash chip enable, active low |
| flashOeN | output | 1 | Flash output enable, active low |
| flashWeN | output | 1 | Flash write enable, active low |
| flashLatchN | output | 1 | Flash address latch, transparent low |
| psramCeN | output | 1 | Pseudo-SRAM chip enable, active low |
| psramZzN | output | 1 | Pseudo-SRAM power-down, active low |
| psramOeN | output | 1 | Pseudo-SRAM output enable, active low |
| psramWeN | output | 1 | Pseudo-SRAM write enable, active low |
| psramUbN | output | 1 | Pseudo-SRAM upper byte enable, active low |
| psramLbN | output | 1 | Pseudo-SRAM lower byte enable, active low |

## Verification
The bench drives reads and writes against behavioural memory models. These models return invalid data until an address has been held for the required number of cycles, so a latency one cycle short shows up as a wrong word rather than passing silently. The read patterns are chosen in pairs to separate the cases:
- a fresh pseudo-SRAM read against follow-on reads in the same page, which exposes the difference between first-access and in-page latency;
- a read just across a page boundary, which exposes any page reuse where a new full access is due;
- flash reads with and without address bit 21 set, which shows whether the top line is routed.

Partial-byte writes followed by full and single-lane reads show lane gating and masking. Requests that switch between the devices, together with a sleep window that contains a flash read, show the bus gap and the power-down hold-off.

// File: rtl/dmcPkg.sv
package dmcPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FL_RD,
    ST_FL_WR,
    ST_PS_RD,
    ST_PS_OPEN,
    ST_PS_WR,
    ST_GAP
  } ctlState_t;

  // strobes from control to datapath, active high
  typedef struct packed {
    logic loadReq;
    logic capture;
    logic flCe;
    logic flOe;
    logic flWe;
    logic flLatch;
    logic psCe;
    logic psOe;
    logic psWe;
    logic psSleep;
    logic dqDrive;
  } strobe_t;

  function automatic int unsigned psToCycles(input int unsigned ps, input int unsigned clkPs);
    int unsigned c;
    c = (ps + clkPs - 1) / clkPs;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned maxOf(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/memBusCtrl.sv
module memBusCtrl
  import dmcPkg::*;
#(
  parameter int unsigned CLK_PS      = 4000,
  parameter int unsigned FLASH_RD_PS = 70000,
  parameter int unsigned PS_FIRST_PS = 70000,
  parameter int unsigned PS_PAGE_PS  = 20000,
  parameter int unsigned WR_PULSE_PS = 45000,
  parameter int unsigned GAP_CYCLES  = 1
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  input  logic    reqTarget,
  input  logic    pageHit,
  input  logic    sleepReq,
  output logic    reqReady,
  output strobe_t strobe
);

  localparam int unsigned FL_RD_CYC = psToCycles(FLASH_RD_PS, CLK_PS);
  localparam int unsigned PS_FIRST_CYC = psToCycles(PS_FIRST_PS, CLK_PS);
  localparam int unsigned PS_PAGE_CYC = psToCycles(PS_PAGE_PS, CLK_PS);
  localparam int unsigned WR_CYC = psToCycles(WR_PULSE_PS, CLK_PS);
  localparam int unsigned GAP_CYC = (GAP_CYCLES == 0) ? 1 : GAP_CYCLES;
  localparam int unsigned MAX_CYC =
    maxOf(maxOf(FL_RD_CYC, PS_FIRST_CYC), maxOf(maxOf(PS_PAGE_CYC, WR_CYC), GAP_CYC));
  localparam int unsigned CNT_W = $clog2(MAX_CYC + 1);

  localparam logic [CNT_W-1:0] FL_RD_LD = CNT_W'(FL_RD_CYC - 1);
  localparam logic [CNT_W-1:0] PS_FIRST_LD = CNT_W'(PS_FIRST_CYC - 1);
  localparam logic [CNT_W-1:0] PS_PAGE_LD = CNT_W'(PS_PAGE_CYC - 1);
  localparam logic [CNT_W-1:0] WR_LD = CNT_W'(WR_CYC - 1);
  localparam logic [CNT_W-1:0] GAP_LD = CNT_W'(GAP_CYC - 1);

  ctlState_t state, nextState;
  logic [CNT_W-1:0] cnt, nextCnt;
  logic firstQ;
  logic sleepQ;
  logic cntDone;

  assign cntDone = (cnt == '0);

  always_comb begin
    nextState = state;
    nextCnt   = cnt;
    reqReady  = 1'b0;
    strobe    = '0;
    strobe.psSleep = sleepQ && !(state inside {ST_PS_RD, ST_PS_OPEN, ST_PS_WR});
    case (state)
      ST_IDLE: begin
        reqReady = !(reqTarget && sleepQ);
        if (reqValid && reqReady) begin
          strobe.loadReq = 1'b1;
          case ({reqTarget, reqWrite})
            2'b00:   begin nextState = ST_FL_RD; nextCnt = FL_RD_LD; end
            2'b01:   begin nextState = ST_FL_WR; nextCnt = WR_LD; end
            2'b10:   begin nextState = ST_PS_RD; nextCnt = PS_FIRST_LD; end
            default: begin nextState = ST_PS_WR; nextCnt = WR_LD; end
          endcase
        end
      end
      ST_FL_RD: begin
        strobe.flCe    = 1'b1;
        strobe.flOe    = 1'b1;
        strobe.flLatch = firstQ;
        if (cntDone) begin
          strobe.capture = 1'b1;
          nextState = ST_GAP;
          nextCnt   = GAP_LD;
        end else begin
          nextCnt = cnt - 1'b1;
        end
      end
      ST_FL_WR: begin
        strobe.flCe    = 1'b1;
        strobe.flWe    = 1'b1;
        strobe.flLatch = firstQ;
        strobe.dqDrive = 1'b1;
        if (cntDone) begin
          nextState = ST_GAP;
          nextCnt   = GAP_LD;
        end else begin
          nextCnt = cnt - 1'b1;
        end
      end
      ST_PS_RD: begin
        strobe.psCe = 1'b1;
        strobe.psOe = 1'b1;
        if (cntDone) begin
          strobe.capture = 1'b1;
          nextState = ST_PS_OPEN;
        end else begin
          nextCnt = cnt - 1'b1;
        end
      end
      ST_PS_OPEN: begin
        strobe.psCe = 1'b1;
        strobe.psOe = 1'b1;
        reqReady = reqTarget && !reqWrite && pageHit && !sleepQ;
        if (reqValid && reqReady) begin
          strobe.loadReq = 1'b1;
          nextState = ST_PS_RD;
          nextCnt   = PS_PAGE_LD;
        end else if (reqValid || sleepQ) begin
          nextState = ST_GAP;
          nextCnt   = GAP_LD;
        end
      end
      ST_PS_WR: begin
        strobe.psCe    = 1'b1;
        strobe.psWe    = 1'b1;
        strobe.dqDrive = 1'b1;
        if (cntDone) begin
          nextState = ST_GAP;
          nextCnt   = GAP_LD;
        end else begin
          nextCnt = cnt - 1'b1;
        end
      end
      ST_GAP: begin
        if (cntDone) nextState = ST_IDLE;
        else nextCnt = cnt - 1'b1;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      firstQ <= 1'b0;
      sleepQ <= 1'b0;
    end else begin
      state  <= nextState;
      cnt    <= nextCnt;
      firstQ <= strobe.loadReq;
      sleepQ <= sleepReq;
    end
  end

endmodule

// File: rtl/memBusDatapath.sv
module memBusDatapath
  import dmcPkg::*;
#(
  parameter int unsigned ADDR_W     = 22,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned PAGE_WORDS = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             strobe,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqWdata,
  input  logic [DATA_W/8-1:0] reqByteEn,
  input  logic [DATA_W-1:0]   memDqIn,
  output logic                pageHit,
  output logic [ADDR_W-2:0]   memAddr,
  output logic                flashAddrTop,
  output logic [DATA_W-1:0]   memDqOut,
  output logic                memDqOe,
  output logic                flashCeN,
  output logic                flashOeN,
  output logic                flashWeN,
  output logic                flashLatchN,
  output logic                psramCeN,
  output logic                psramZzN,
  output logic                psramOeN,
  output logic                psramWeN,
  output logic [DATA_W/8-1:0] psramBeN,
  output logic                rspValid,
  output logic [DATA_W-1:0]   rspData
);

  localparam int unsigned LANES = DATA_W / 8;
  localparam int unsigned PAGE_BITS = $clog2(PAGE_WORDS);
  localparam int unsigned SHARED_W = ADDR_W - 1;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [LANES-1:0]  beQ;
  logic [DATA_W-1:0] rdMasked;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      beQ    <= '0;
    end else if (strobe.loadReq) begin
      addrQ  <= reqAddr;
      wdataQ <= reqWdata;
      beQ    <= reqByteEn;
    end
  end

  assign pageHit = (reqAddr[ADDR_W-1:PAGE_BITS] == addrQ[ADDR_W-1:PAGE_BITS]);

  // flash reads are whole words; pseudo-SRAM reads keep enabled lanes only
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic keep;
    assign keep = strobe.psCe ? beQ[l] : 1'b1;
    assign rdMasked[l*8 +: 8] = keep ? memDqIn[l*8 +: 8] : 8'h00;
    assign psramBeN[l] = !(strobe.psCe && beQ[l]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= strobe.capture;
      if (strobe.capture) rspData <= rdMasked;
    end
  end

  assign memAddr      = addrQ[SHARED_W-1:0];
  assign flashAddrTop = strobe.flCe && addrQ[ADDR_W-1];
  assign memDqOut     = wdataQ;
  assign memDqOe      = strobe.dqDrive;
  assign flashCeN     = !strobe.flCe;
  assign flashOeN     = !strobe.flOe;
  assign flashWeN     = !strobe.flWe;
  assign flashLatchN  = !strobe.flLatch;
  assign psramCeN     = !strobe.psCe;
  assign psramOeN     = !strobe.psOe;
  assign psramWeN     = !strobe.psWe;
  assign psramZzN     = !strobe.psSleep;

endmodule

// File: rtl/dualMemBusCtrl.sv
module dualMemBusCtrl
  import dmcPkg::*;
#(
  parameter int unsigned CLK_PS      = 4000,
  parameter int unsigned FLASH_RD_PS = 70000,
  parameter int unsigned PS_FIRST_PS = 70000,
  parameter int unsigned PS_PAGE_PS  = 20000,
  parameter int unsigned WR_PULSE_PS = 45000,
  parameter int unsigned GAP_CYCLES  = 1,
  parameter int unsigned PAGE_WORDS  = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic        reqWrite,
  input  logic        reqTarget,
  input  logic [21:0] reqAddr,
  input  logic [15:0] reqWdata,
  input  logic [1:0]  reqByteEn,
  input  logic        psramSleep,
  output logic        rspValid,
  output logic [15:0] rspData,
  output logic [20:0] memAddr,
  output logic        flashAddrTop,
  output logic [15:0] memDqOut,
  output logic        memDqOe,
  input  logic [15:0] memDqIn,
  output logic        flashCeN,
  output logic        flashOeN,
  output logic        flashWeN,
  output logic        flashLatchN,
  output logic        psramCeN,
  output logic        psramZzN,
  output logic        psramOeN,
  output logic        psramWeN,
  output logic        psramUbN,
  output logic        psramLbN
);

  strobe_t strobe;
  logic    pageHit;
  logic [1:0] psramBeN;

  memBusCtrl #(
    .CLK_PS(CLK_PS), .FLASH_RD_PS(FLASH_RD_PS), .PS_FIRST_PS(PS_FIRST_PS),
    .PS_PAGE_PS(PS_PAGE_PS), .WR_PULSE_PS(WR_PULSE_PS), .GAP_CYCLES(GAP_CYCLES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqTarget(reqTarget), .pageHit(pageHit), .sleepReq(psramSleep),
    .reqReady(reqReady), .strobe(strobe)
  );

  memBusDatapath #(
    .ADDR_W(22), .DATA_W(16), .PAGE_WORDS(PAGE_WORDS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .reqByteEn(reqByteEn), .memDqIn(memDqIn),
    .pageHit(pageHit), .memAddr(memAddr), .flashAddrTop(flashAddrTop),
    .memDqOut(memDqOut), .memDqOe(memDqOe), .flashCeN(flashCeN),
    .flashOeN(flashOeN), .flashWeN(flashWeN), .flashLatchN(flashLatchN),
    .psramCeN(psramCeN), .psramZzN(psramZzN), .psramOeN(psramOeN),
    .psramWeN(psramWeN), .psramBeN(psramBeN), .rspValid(rspValid),
    .rspData(rspData)
  );

  assign psramUbN = psramBeN[1];
  assign psramLbN = psramBeN[0];

endmodule

// File: rtl/dualMemBusChk.sv
module dualMemBusChk (
  input logic        clk,
  input logic        rstN,
  input logic [20:0] memAddr,
  input logic        flashAddrTop,
  input logic        memDqOe,
  input logic        flashCeN,
  input logic        flashOeN,
  input logic        flashWeN,
  input logic        flashLatchN,
  input logic        psramCeN,
  input logic        psramZzN,
  input logic        psramWeN,
  input logic        psramUbN,
  input logic        psramLbN
);

  // R2
  one_owner_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!flashCeN && !psramCeN));

  // R2
  flash_to_psram_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    !flashCeN |=> psramCeN);

  // R2
  psram_to_flash_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    !psramCeN |=> flashCeN);

  // R3
  latch_inside_ce_chk: assert property (@(posedge clk) disable iff (!rstN)
    !flashLatchN |-> !flashCeN);

  // R3
  latch_single_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !flashLatchN |=> flashLatchN);

  // R4
  flash_oe_we_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!flashOeN && !flashWeN));

  // R4
  drive_only_on_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    memDqOe |-> (!flashWeN || !psramWeN));

  // R6
  page_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!psramCeN && $past(!psramCeN)) |-> (memAddr[20:3] == $past(memAddr[20:3])));

  // R8
  byte_en_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    psramCeN |-> (psramUbN && psramLbN));

  // R9
  top_addr_flash_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    flashAddrTop |-> !flashCeN);

  // R10
  sleep_not_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    !psramZzN |-> psramCeN);

endmodule

bind dualMemBusCtrl dualMemBusChk u_dualMemBusChk (.*);

// File: tb/test_dualMemBusCtrl.sv
`timescale 1ns/1ps
module test_dualMemBusCtrl;

  localparam int CLK_PS = 4000;
  localparam int FL_CYC = (70000 + CLK_PS - 1) / CLK_PS;
  localparam int FIRST_CYC = (70000 + CLK_PS - 1) / CLK_PS;
  localparam int PAGE_CYC = (20000 + CLK_PS - 1) / CLK_PS;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, reqTarget = 1'b0, psramSleep = 1'b0;
  logic [21:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic [1:0] reqByteEn = 2'b11;
  logic reqReady, rspValid, flashAddrTop, memDqOe;
  logic [15:0] rspData, memDqOut, memDqIn;
  logic [20:0] memAddr;
  logic flashCeN, flashOeN, flashWeN, flashLatchN;
  logic psramCeN, psramZzN, psramOeN, psramWeN, psramUbN, psramLbN;

  always #2 clk = ~clk;

  dualMemBusCtrl #(.CLK_PS(CLK_PS)) i_dualMemBusCtrl (.*);

  int checks = 0, fails = 0, cycCnt = 0;
  int contention = 0, gapViol = 0, topViol = 0, rspSeen = 0, readsIssued = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) cycCnt <= cycCnt + 1;

  // ---------------- memory models ----------------
  logic [15:0] flashMem [64];
  logic [15:0] psramMem [64];
  logic [15:0] flashShadow [64];
  logic [15:0] psramShadow [64];

  function automatic logic [5:0] fIdx(input logic [21:0] a);
    return {a[21], a[4:0]};
  endfunction

  initial begin
    for (int i = 0; i < 64; i++) begin
      flashMem[i] = 16'hA000 + 16'(i * 16'h0111);
      psramMem[i] = 16'h3C00 ^ 16'(i * 16'h0123);
      flashShadow[i] = flashMem[i];
      psramShadow[i] = psramMem[i];
    end
  end

  logic [21:0] flLat = '0;
  always @* if (!flashLatchN) flLat = {flashAddrTop, memAddr};

  int flCnt = 0;
  logic flWePrev = 1'b0;
  logic [21:0] flWrAddr = '0;
  logic [15:0] flWrData = '0;
  always @(posedge clk) begin
    flCnt <= flashCeN ? 0 : flCnt + 1;
    flWePrev <= !flashCeN && !flashWeN;
    if (!flashCeN && !flashWeN) begin
      flWrAddr <= flLat;
      flWrData <= memDqOe ? memDqOut : 16'h0BAD;
    end
    if (flWePrev && (flashCeN || flashWeN)) flashMem[fIdx(flWrAddr)] <= flWrData;
  end

  int psCnt = 0, psNeed = 0;
  logic psOpen = 1'b0;
  logic [20:0] psLast = '0;
  logic psWePrev = 1'b0;
  logic [20:0] psWrAddr = '0;
  logic [15:0] psWrData = '0;
  logic [1:0] psWrBeN = 2'b11;
  always @(posedge clk) begin
    if (psramCeN || !psramZzN) begin
      psCnt <= 0;
      psOpen <= 1'b0;
    end else if (!psOpen || memAddr != psLast) begin
      psCnt <= 1;
      psLast <= memAddr;
      psNeed <= (psOpen && memAddr[20:3] == psLast[20:3]) ? PAGE_CYC : FIRST_CYC;
      psOpen <= 1'b1;
    end else begin
      psCnt <= psCnt + 1;
    end
    psWePrev <= !psramCeN && !psramWeN;
    if (!psramCeN && !psramWeN) begin
      psWrAddr <= memAddr;
      psWrData <= memDqOe ? memDqOut : 16'h0BAD;
      psWrBeN <= {psramUbN, psramLbN};
    end
    if (psWePrev && (psramCeN || psramWeN)) begin
      if (!psWrBeN[1]) psramMem[psWrAddr[5:0]][15:8] <= psWrData[15:8];
      if (!psWrBeN[0]) psramMem[psWrAddr[5:0]][7:0] <= psWrData[7:0];
    end
  end

  logic flDrive, psDrive;
  logic [15:0] flWord, psWord;
  always @* begin
    flDrive = !flashCeN && !flashOeN;
    psDrive = !psramCeN && !psramOeN && psramZzN;
    flWord = (flCnt + 1 >= FL_CYC) ? flashMem[fIdx(flLat)] : 16'hBAD0;
    psWord = (psOpen && memAddr == psLast && psCnt + 1 >= psNeed) ? psramMem[memAddr[5:0]] : 16'hBAD1;
    if (psramUbN) psWord[15:8] = 8'hEE;
    if (psramLbN) psWord[7:0] = 8'hEE;
    memDqIn = flDrive ? flWord : (psDrive ? psWord : 16'hDEAD);
  end

  // ---------------- bus monitor ----------------
  logic prevFl = 1'b0, prevPs = 1'b0;
  always @(negedge clk) begin
    if (rstN) begin
      if (!flashCeN && !psramCeN) contention++;
      if (prevPs && !flashCeN) gapViol++;
      if (prevFl && !psramCeN) gapViol++;
      if (!psramCeN && flashAddrTop) topViol++;
    end
    prevFl = !flashCeN;
    prevPs = !psramCeN;
  end

  // ---------------- scoreboard ----------------
  typedef struct {
    logic [15:0] data;
    int lat;
    int acc;
    string tag;
  } exp_t;
  exp_t expQ[$];

  always @(negedge clk) begin
    if (rstN && rspValid) begin
      rspSeen++;
      if (expQ.size() == 0) begin
        chk(1'b0, "R11 unexpected response", 32'(rspData), 32'h0);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        chk(rspData == e.data, {e.tag, " data"}, 32'(rspData), 32'(e.data));
        chk(cycCnt - e.acc == e.lat, {e.tag, " latency"}, 32'(cycCnt - e.acc), 32'(e.lat));
      end
    end
  end

  task automatic issue(input bit wr, input bit tgt, input logic [21:0] a,
                       input logic [15:0] d, input logic [1:0] be,
                       input int lat, input string tag);
    exp_t e;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqTarget = tgt;
    reqAddr = a; reqWdata = d; reqByteEn = be;
    #1;
    while (!reqReady) begin
      @(negedge clk);
      #1;
    end
    if (wr) begin
      if (tgt) begin
        if (be[1]) psramShadow[a[5:0]][15:8] = d[15:8];
        if (be[0]) psramShadow[a[5:0]][7:0] = d[7:0];
      end else begin
        flashShadow[fIdx(a)] = d;
      end
    end else begin
      readsIssued++;
      if (tgt) begin
        e.data = psramShadow[a[5:0]];
        if (!be[1]) e.data[15:8] = 8'h00;
        if (!be[0]) e.data[7:0] = 8'h00;
      end else begin
        e.data = flashShadow[fIdx(a)];
      end
      e.lat = lat; e.acc = cycCnt + 1; e.tag = tag;
      expQ.push_back(e);
    end
    @(posedge clk);
    #1 reqValid = 1'b0;
  endtask

  task automatic drain();
    int guard = 0;
    while (expQ.size() != 0 && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    repeat (3) @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    // R1 reset state
    chk(flashCeN && flashOeN && flashWeN && flashLatchN, "R1 flash strobes",
        {28'h0, flashCeN, flashOeN, flashWeN, flashLatchN}, 32'hF);
    chk(psramCeN && psramOeN && psramWeN && psramUbN && psramLbN, "R1 psram strobes",
        {27'h0, psramCeN, psramOeN, psramWeN, psramUbN, psramLbN}, 32'h1F);
    chk(psramZzN && !memDqOe && !rspValid, "R1 zz/drive/rsp",
        {29'h0, psramZzN, memDqOe, rspValid}, 32'h4);
    chk(reqReady, "R1 ready", 32'(reqReady), 32'h1);

    // R3 flash reads, R9 top address bit
    issue(0, 0, 22'h000005, 16'h0, 2'b11, FL_CYC, "R3 flash read");
    issue(0, 0, 22'h200005, 16'h0, 2'b11, FL_CYC, "R9 flash read bit21");
    // R4 flash write then read back
    issue(1, 0, 22'h000007, 16'h1234, 2'b11, 0, "R4 flash write");
    issue(0, 0, 22'h000007, 16'h0, 2'b11, FL_CYC, "R4 flash readback");
    // R5 first access, R6 page hits, R7 page miss
    issue(0, 1, 22'h000010, 16'h0, 2'b11, FIRST_CYC, "R5 psram first");
    issue(0, 1, 22'h000013, 16'h0, 2'b11, PAGE_CYC, "R6 page hit a");
    issue(0, 1, 22'h000017, 16'h0, 2'b11, PAGE_CYC, "R6 page hit b");
    issue(0, 1, 22'h000018, 16'h0, 2'b11, FIRST_CYC, "R7 page miss");
    // R8 partial write, full read, single-lane page read
    issue(1, 1, 22'h000021, 16'hABCD, 2'b10, 0, "R8 upper write");
    issue(0, 1, 22'h000021, 16'h0, 2'b11, FIRST_CYC, "R8 full read");
    issue(0, 1, 22'h000021, 16'h0, 2'b01, PAGE_CYC, "R8 lower read");
    // R2 switch back to flash
    issue(0, 0, 22'h000003, 16'h0, 2'b11, FL_CYC, "R2 flash after psram");
    drain();

    // R10 sleep
    psramSleep = 1'b1;
    reqTarget = 1'b1; reqWrite = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(!psramZzN, "R10 power-down low", 32'(psramZzN), 32'h0);
    chk(!reqReady, "R10 psram held off", 32'(reqReady), 32'h0);
    issue(0, 0, 22'h000009, 16'h0, 2'b11, FL_CYC, "R10 flash in sleep");
    drain();
    chk(!psramZzN, "R10 still asleep", 32'(psramZzN), 32'h0);
    psramSleep = 1'b0;
    repeat (3) @(negedge clk);
    chk(psramZzN, "R10 wake", 32'(psramZzN), 32'h1);
    issue(0, 1, 22'h000030, 16'h0, 2'b11, FIRST_CYC, "R10 psram after wake");

    // R11 ready low during access
    issue(0, 0, 22'h000001, 16'h0, 2'b11, FL_CYC, "R11 flash read");
    chk(!reqReady, "R11 ready during access", 32'(reqReady), 32'h0);
    drain();

    chk(contention == 0, "R2 contention cycles", 32'(contention), 32'h0);
    chk(gapViol == 0, "R2 missing gap", 32'(gapViol), 32'h0);
    chk(topViol == 0, "R9 top bit in psram access", 32'(topViol), 32'h0);
    chk(rspSeen == readsIssued, "R11 response count", 32'(rspSeen), 32'(readsIssued));

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule